// File: doc/BRIEF.md
# Masked Window Register Copy Channel

This block is a single DMA channel that moves configuration registers between memory and a register space. Each command covers one or more windows. A window is a run of 32 consecutive 32-bit words. A 32-bit mask chooses which words in a window are moved, and the same mask applies to every window of the command. Words whose mask bit is clear get no bus access at all. This lets software update a scattered set of registers with one command while leaving the registers between them untouched.

Software fills three staging registers for the mask, the source base and the destination base. It then writes a control word that holds the window count and the interrupt enable, and that write commits the command. The channel has one bus master port with a request/acknowledge handshake. Through it the channel reads each selected word from the source and writes it to the matching offset at the destination. The channel has two status outputs. One shows that a command is running, and the other shows that a further command is queued. A one-cycle interrupt pulse can mark the end of each command.

Top module: `cfg_window_mover`

## Requirements
- R1: A `cfg_wr` cycle stores `cfg_wdata` into the register picked by `cfg_sel`: 0 = mask, 1 = source base, 2 = destination base. Selector 3 is the control word, whose bits [3:0] hold the window field and bit 4 the interrupt enable. Writing it commits a command built from the most recent mask, source and destination values.
- R2: For every word whose mask bit is 1, the channel makes exactly one read at the source word address. The next bus access is one write of the returned data to the destination word address at the same offset.
- R3: Word i of window w sits at base + 128*w + 4*i. Words are served in ascending i inside a window, and windows in ascending w.
- R4: The control field value n gives n+1 windows, so one command covers 1 to 16 windows.
- R5: Address bits [4:0] written to the source and destination registers are ignored, so every base is 32-byte aligned.
- R6: A word whose mask bit is 0 causes no bus access. With an all-zero mask the command still walks every window and then completes normally.
- R7: `irq_done` is high for exactly one cycle, in the cycle right after the acknowledge of the command's final access (or after its final window is walked). It rises only when the interrupt enable of that command was 1.
- R8: `stat_active` is high from the cycle after a command is accepted until the cycle of its final access acknowledge. No bus request is made while it is low.
- R9: `stat_pending` rises when a command is committed while another is running. It falls in the cycle the queued command is accepted. A commit while a command is already pending replaces that pending command.
- R10: Once raised, `mem_req` holds its address, direction and write data stable until `mem_ack` is seen.
- R11: After reset there is no request, and `stat_active`, `stat_pending` and `irq_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | 32 | Register write data |
| stat_pending | output | 1 | A committed command waits behind the running one |
| stat_active | output | 1 | A command is running |
| irq_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus direction, 1 = write |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | 32 | Bus read data |

## Verification
The hardest case to reach is the queue. A commit has to arrive while another command is running, then a second commit has to replace it before it starts, and finally the queued command has to be accepted just after the running one ends. The bench makes the first command long, using a full mask over two windows and a memory model that adds varying wait states. This leaves time to commit two more commands behind it. The bench then checks that only the last of those two follows on the bus, and that the pending flag drops when it starts.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SCAN = 3'd1,
      ST_RD   = 3'd2,
      ST_WR   = 3'd3,
      ST_FIN  = 3'd4
   } cwm_state_e;

   localparam logic [1:0] SEL_MASK = 2'd0;
   localparam logic [1:0] SEL_SRC  = 2'd1;
   localparam logic [1:0] SEL_DST  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/cwm_cmd_queue.sv
module cwm_cmd_queue
   import cwm_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int MASK_W   = 32,
   parameter int CNT_W    = 4,
   parameter int ALIGN_SH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              engaged,
   input  logic              take,
   output logic              slot_vld,
   output logic [MASK_W-1:0] slot_mask,
   output logic [ADDR_W-1:0] slot_src,
   output logic [ADDR_W-1:0] slot_dst,
   output logic [CNT_W-1:0]  slot_cnt,
   output logic              slot_ie,
   output logic              pending
);

   localparam int IE_BIT = CNT_W;

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("cwm_cmd_queue: ADDR_W must not exceed DATA_W");
   end
   if (IE_BIT >= DATA_W) begin : g_bad_ctrl
      $error("cwm_cmd_queue: control word does not fit DATA_W");
   end

   logic [MASK_W-1:0] stg_mask;
   logic [ADDR_W-1:0] stg_src;
   logic [ADDR_W-1:0] stg_dst;
   logic              commit;

   assign commit = cfg_wr && (cfg_sel == SEL_CTRL);

   // staging registers; low address bits dropped at entry (R5)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_mask <= '0;
         stg_src  <= '0;
         stg_dst  <= '0;
      end else if (cfg_wr) begin
         case (cfg_sel)
            SEL_MASK: stg_mask <= cfg_wdata[MASK_W-1:0];
            SEL_SRC:  stg_src  <= {cfg_wdata[ADDR_W-1:ALIGN_SH], {ALIGN_SH{1'b0}}};
            SEL_DST:  stg_dst  <= {cfg_wdata[ADDR_W-1:ALIGN_SH], {ALIGN_SH{1'b0}}};
            default:  ;
         endcase
      end
   end

   // single command slot, newest commit wins (R9)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld  <= 1'b0;
         slot_mask <= '0;
         slot_src  <= '0;
         slot_dst  <= '0;
         slot_cnt  <= '0;
         slot_ie   <= 1'b0;
         pending   <= 1'b0;
      end else begin
         if (commit) begin
            slot_vld  <= 1'b1;
            slot_mask <= stg_mask;
            slot_src  <= stg_src;
            slot_dst  <= stg_dst;
            slot_cnt  <= cfg_wdata[CNT_W-1:0];
            slot_ie   <= cfg_wdata[IE_BIT];
         end else if (take) begin
            slot_vld  <= 1'b0;
         end
         if (commit && (engaged || take)) begin
            pending <= 1'b1;
         end else if (take) begin
            pending <= 1'b0;
         end
      end
   end

   p_pend_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(take));

   p_pend_queued_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> slot_vld);

endmodule

// File: rtl/cwm_word_pick.sv
module cwm_word_pick #(
   parameter int MASK_W    = 32,
   parameter bit LOOKAHEAD = 1'b1,
   localparam int IDX_W    = $clog2(MASK_W)
) (
   input  logic [MASK_W-1:0] mask,
   input  logic [IDX_W-1:0]  idx,
   output logic              found,
   output logic [IDX_W-1:0]  pick,
   output logic              win_end
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MASK_W - 1);

   if (LOOKAHEAD) begin : g_jump
      // lowest enabled word at or above idx, found in one cycle
      always_comb begin
         found = 1'b0;
         pick  = idx;
         for (int k = MASK_W - 1; k >= 0; k--) begin
            if (mask[k] && (k >= int'(idx))) begin
               found = 1'b1;
               pick  = IDX_W'(k);
            end
         end
         win_end = !found;
      end
   end else begin : g_step
      // one word examined per cycle
      always_comb begin
         found   = mask[idx];
         pick    = idx;
         win_end = !mask[idx] && (idx == LAST_IDX);
      end
   end

endmodule

// File: rtl/cwm_engine.sv
module cwm_engine
   import cwm_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int MASK_W    = 32,
   parameter int CNT_W     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_vld,
   input  logic [MASK_W-1:0] slot_mask,
   input  logic [ADDR_W-1:0] slot_src,
   input  logic [ADDR_W-1:0] slot_dst,
   input  logic [CNT_W-1:0]  slot_cnt,
   input  logic              slot_ie,
   output logic              take,
   output logic              engaged,
   output logic              active,
   output logic              irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int BYTE_SH    = $clog2(WORD_BYTES);
   localparam int IDX_W      = $clog2(MASK_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MASK_W - 1);

   if (CNT_W + IDX_W + BYTE_SH > ADDR_W) begin : g_bad_span
      $error("cwm_engine: command span exceeds address width");
   end

   cwm_state_e        state;
   logic [MASK_W-1:0] mask_q;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ie_q;
   logic [CNT_W-1:0]  win_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] buf_q;
   logic              found;
   logic [IDX_W-1:0]  pick;
   logic              win_end;
   logic              last_win;
   logic [ADDR_W-1:0] offs;

   cwm_word_pick #(
      .MASK_W    (MASK_W),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_pick (
      .mask    (mask_q),
      .idx     (idx_q),
      .found   (found),
      .pick    (pick),
      .win_end (win_end)
   );

   assign last_win  = (win_q == cnt_q);
   assign offs      = ADDR_W'({win_q, idx_q}) << BYTE_SH;   // R3
   assign take      = (state == ST_IDLE) && slot_vld;
   assign engaged   = (state != ST_IDLE);
   assign active    = (state == ST_SCAN) || (state == ST_RD) || (state == ST_WR);
   assign irq       = (state == ST_FIN) && ie_q;
   assign mem_req   = (state == ST_RD) || (state == ST_WR);
   assign mem_we    = (state == ST_WR);
   assign mem_addr  = ((state == ST_WR) ? dst_q : src_q) + offs;
   assign mem_wdata = buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mask_q <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ie_q   <= 1'b0;
         win_q  <= '0;
         idx_q  <= '0;
         buf_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (slot_vld) begin
                  mask_q <= slot_mask;
                  src_q  <= slot_src;
                  dst_q  <= slot_dst;
                  cnt_q  <= slot_cnt;
                  ie_q   <= slot_ie;
                  win_q  <= '0;
                  idx_q  <= '0;
                  state  <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (found) begin
                  idx_q <= pick;
                  state <= ST_RD;
               end else if (win_end) begin
                  if (last_win) begin
                     state <= ST_FIN;
                  end else begin
                     win_q <= win_q + CNT_W'(1);
                     idx_q <= '0;
                  end
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            ST_RD: begin
               if (mem_ack) begin
                  buf_q <= mem_rdata;
                  state <= ST_WR;
               end
            end
            ST_WR: begin
               if (mem_ack) begin
                  if (idx_q == LAST_IDX) begin
                     if (last_win) begin
                        state <= ST_FIN;
                     end else begin
                        win_q <= win_q + CNT_W'(1);
                        idx_q <= '0;
                        state <= ST_SCAN;
                     end
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                     state <= ST_SCAN;
                  end
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));

   p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(mem_ack) && !$past(mem_we));

   p_rd_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mask_q[idx_q]);

   p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(active) && !active);

endmodule

// File: rtl/cfg_window_mover.sv
module cfg_window_mover #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int WIN_WORDS   = 32,
   parameter int CNT_W       = 4,
   parameter int ALIGN_BYTES = 32,
   parameter bit LOOKAHEAD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              stat_pending,
   output logic              stat_active,
   output logic              irq_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int ALIGN_SH   = $clog2(ALIGN_BYTES);
   localparam int WORD_BYTES = DATA_W / 8;

   if ((DATA_W % 8) != 0) begin : g_bad_data
      $error("cfg_window_mover: DATA_W must be a whole number of bytes");
   end
   if ((WIN_WORDS & (WIN_WORDS - 1)) != 0 || WIN_WORDS < 2) begin : g_bad_win
      $error("cfg_window_mover: WIN_WORDS must be a power of two of at least 2");
   end
   if (WIN_WORDS > DATA_W) begin : g_bad_mask
      $error("cfg_window_mover: mask must fit in one register write");
   end
   if ((ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0 || ALIGN_BYTES < WORD_BYTES) begin : g_bad_align
      $error("cfg_window_mover: ALIGN_BYTES must be a power of two of at least one word");
   end

   logic                 slot_vld;
   logic [WIN_WORDS-1:0] slot_mask;
   logic [ADDR_W-1:0]    slot_src;
   logic [ADDR_W-1:0]    slot_dst;
   logic [CNT_W-1:0]     slot_cnt;
   logic                 slot_ie;
   logic                 take;
   logic                 engaged;

   cwm_cmd_queue #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .MASK_W   (WIN_WORDS),
      .CNT_W    (CNT_W),
      .ALIGN_SH (ALIGN_SH)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .engaged   (engaged),
      .take      (take),
      .slot_vld  (slot_vld),
      .slot_mask (slot_mask),
      .slot_src  (slot_src),
      .slot_dst  (slot_dst),
      .slot_cnt  (slot_cnt),
      .slot_ie   (slot_ie),
      .pending   (stat_pending)
   );

   cwm_engine #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MASK_W    (WIN_WORDS),
      .CNT_W     (CNT_W),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_vld  (slot_vld),
      .slot_mask (slot_mask),
      .slot_src  (slot_src),
      .slot_dst  (slot_dst),
      .slot_cnt  (slot_cnt),
      .slot_ie   (slot_ie),
      .take      (take),
      .engaged   (engaged),
      .active    (stat_active),
      .irq       (irq_done),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> stat_active);

   p_pend_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_pending) |-> $past(cfg_wr) && ($past(cfg_sel) == 2'd3));

endmodule

// File: tb/cfg_window_mover_test.sv
module cfg_window_mover_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic        stat_pending, stat_active, irq_done;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   int mon_bad = 0;
   int irq_cnt = 0;

   logic        lg_we   [0:1199];
   logic [31:0] lg_addr [0:1199];
   logic [31:0] lg_data [0:1199];
   int          lg_n = 0;
   int          wait_cnt = 0;

   logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0, p_act = 1'b0, p_irq = 1'b0;
   logic [31:0] p_addr = '0;

   always #4 clk = ~clk;

   cfg_window_mover uut (
      .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_sel (cfg_sel),
      .cfg_wdata (cfg_wdata), .stat_pending (stat_pending),
      .stat_active (stat_active), .irq_done (irq_done), .mem_req (mem_req),
      .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_ack (mem_ack), .mem_rdata (mem_rdata)
   );

   function automatic logic [31:0] fdat(input logic [31:0] a);
      return a ^ 32'hC3A5_5A3C;
   endfunction

   // memory model and protocol monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (p_req && !p_ack && !(mem_req && mem_addr == p_addr && mem_we == p_we))
            mon_bad++;                                   // R10
         if (mem_req && !stat_active) mon_bad++;         // R8
         if (irq_done) begin
            irq_cnt++;
            if (p_irq || !(p_act && !stat_active)) mon_bad++;   // R7
         end
         p_req = mem_req; p_addr = mem_addr; p_we = mem_we;
         p_act = stat_active; p_irq = irq_done;
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (wait_cnt == 0) begin
               lg_we[lg_n] = mem_we;
               lg_addr[lg_n] = mem_addr;
               lg_data[lg_n] = mem_wdata;
               lg_n++;
               mem_rdata = fdat(mem_addr);
               mem_ack = 1'b1;
               wait_cnt = lg_n % 3;
            end else begin
               wait_cnt--;
            end
         end
         p_ack = mem_ack;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic launch(input logic [31:0] m, input logic [31:0] s,
                         input logic [31:0] d, input int cnt, input bit ie);
      cfg(2'd0, m);
      cfg(2'd1, s);
      cfg(2'd2, d);
      cfg(2'd3, 32'(cnt) | (ie ? 32'h10 : 32'h0));
   endtask

   task automatic wait_rise();
      for (int n = 0; n < 5000 && !stat_active; n++) @(negedge clk);
   endtask

   task automatic wait_fall();
      for (int n = 0; n < 20000 && stat_active; n++) @(negedge clk);
   endtask

   // compare the bus log from index start against the expected word order
   task automatic chk_seq(input string req, input logic [31:0] m, input logic [31:0] s,
                          input logic [31:0] d, input int cnt, input int start,
                          output int next);
      int k = start;
      bit ok = 1'b1;
      logic [31:0] sa = s & ~32'h1F;
      logic [31:0] da = d & ~32'h1F;
      for (int w = 0; w <= cnt; w++) begin
         for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
               logic [31:0] ra = sa + 32'(w * 128 + i * 4);
               logic [31:0] wa = da + 32'(w * 128 + i * 4);
               if (ok && (k + 1 >= lg_n || lg_we[k] || lg_addr[k] != ra)) begin
                  ok = 1'b0;
                  check(1'b0, req, "read address", (k < lg_n) ? lg_addr[k] : 32'hX, ra);
               end
               if (ok && (!lg_we[k+1] || lg_addr[k+1] != wa || lg_data[k+1] != fdat(ra))) begin
                  ok = 1'b0;
                  check(1'b0, req, "write addr/data", lg_data[k+1], fdat(ra));
               end
               k += 2;
            end
         end
      end
      if (ok) check(1'b1, req, "sequence", 0, 0);
      next = k;
   endtask

   task automatic t_reset();
      check(!stat_active, "R11", "active after reset", 32'(stat_active), 0);
      check(!stat_pending, "R11", "pending after reset", 32'(stat_pending), 0);
      check(!irq_done, "R11", "irq after reset", 32'(irq_done), 0);
      check(!mem_req, "R11", "request after reset", 32'(mem_req), 0);
   endtask

   task automatic t_run(input string req, input logic [31:0] m, input logic [31:0] s,
                        input logic [31:0] d, input int cnt, input bit ie);
      int base = lg_n;
      int irq0 = irq_cnt;
      int nxt;
      launch(m, s, d, cnt, ie);
      wait_rise();
      check(stat_active, req, "active seen", 32'(stat_active), 1);
      wait_fall();
      repeat (3) @(negedge clk);
      chk_seq(req, m, s, d, cnt, base, nxt);
      check(nxt == lg_n, req, "access count", 32'(lg_n - base), 32'(nxt - base));
      check(irq_cnt - irq0 == int'(ie), "R7", "irq pulses", 32'(irq_cnt - irq0), 32'(ie));
   endtask

   // R1: staging rewrites before commit, only latest values used
   task automatic t_regsel();
      int base = lg_n;
      int nxt;
      cfg(2'd0, 32'hFFFF_FFFF);
      cfg(2'd1, 32'h7000_0000);
      cfg(2'd2, 32'h7100_0000);
      cfg(2'd0, 32'h0000_0240);
      cfg(2'd2, 32'h7200_0080);
      cfg(2'd3, 32'h0000_0000);
      wait_rise();
      wait_fall();
      repeat (3) @(negedge clk);
      chk_seq("R1", 32'h0000_0240, 32'h7000_0000, 32'h7200_0080, 0, base, nxt);
      check(nxt == lg_n, "R1", "access count", 32'(lg_n - base), 32'(nxt - base));
   endtask

   // R9: queue one, replace it, check only the replacement runs
   task automatic t_queue();
      int base = lg_n;
      int irq0 = irq_cnt;
      int nxt;
      launch(32'hFFFF_FFFF, 32'h4000_0000, 32'h4100_0000, 1, 1'b0);
      wait_rise();
      launch(32'h0000_0005, 32'h4200_0000, 32'h4300_0000, 0, 1'b0);
      @(negedge clk);
      check(stat_pending, "R9", "pending after queued commit", 32'(stat_pending), 1);
      launch(32'h8000_0102, 32'h4400_0000, 32'h4500_0020, 0, 1'b1);
      @(negedge clk);
      check(stat_pending && stat_active, "R9", "still pending behind run",
            32'(stat_pending), 1);
      wait_fall();
      wait_rise();
      check(!stat_pending, "R9", "pending cleared at start", 32'(stat_pending), 0);
      wait_fall();
      repeat (3) @(negedge clk);
      chk_seq("R9", 32'hFFFF_FFFF, 32'h4000_0000, 32'h4100_0000, 1, base, nxt);
      chk_seq("R9", 32'h8000_0102, 32'h4400_0000, 32'h4500_0020, 0, nxt, nxt);
      check(nxt == lg_n, "R9", "replaced command absent", 32'(lg_n - base), 32'(nxt - base));
      check(irq_cnt - irq0 == 1, "R7", "irq only for enabled command",
            32'(irq_cnt - irq0), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run("R2", 32'hFFFF_FFFF, 32'h1000_0000, 32'h2000_0040, 0, 1'b1);
      t_run("R5", 32'h8000_0011, 32'h1000_0013, 32'h3000_002C, 2, 1'b1);
      t_run("R6", 32'h0000_0000, 32'h1000_0000, 32'h2000_0000, 15, 1'b1);
      t_run("R4", 32'h8000_0000, 32'h5000_0000, 32'h6000_0000, 15, 1'b0);
      t_run("R3", 32'h0F00_00F0, 32'h0000_1000, 32'h0000_8000, 3, 1'b1);
      t_regsel();
      t_queue();
      check(mon_bad == 0, "R10", "protocol/active/irq monitor errors", 32'(mon_bad), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule